// File: doc/BRIEF.md
# Virtual Address Translation Checker

This block sits in the path between a processor's AHB-Lite master and the memory controller. It presents a slave port to the processor and a master port to memory. Every transfer the processor starts is classified by a single address bit, bit 26. When bit 26 is clear the address is physical. When bit 26 is set the address is virtual.

A physical address goes to memory exactly as issued, but only while the processor runs in system mode. A virtual address is looked up in a 32-entry page table that comes in as a flat input vector. The lookup matches on the page-number field of the address and on the current context ID. On a valid hit with the needed permission, the page bits are swapped for the entry's physical frame and the transfer goes to memory. Any other outcome is a fault: the block issues no memory transfer, completes the processor's transfer quietly and pulses an interrupt.

The mode, the context ID and the table contents are inputs that a supervising agent drives. Loading the table, bursts, and split or retry responses lie outside the block.

Top module: `vat_check`

## Requirements
- R1: A transfer whose address bit 26 is clear is physical. In system mode (`sys_mode_i`=1) it is issued on the master port with the identical 32-bit address, direction and size.
- R2: A physical transfer in user mode (`sys_mode_i`=0) is refused: no master transfer, and it is handled as a fault.
- R3: A transfer with bit 26 set takes its page number from address bits [20:9] and its offset from bits [8:0]. On a usable hit the master address is {5'b0, frame[17:0], offset[8:0]}. Address bits outside [20:0] do not affect the result.
- R4: Each table entry is 36 bits wide, and entry k occupies `tbl_i[36k+35:36k]`. The fields are: valid at bit 35, write-allowed at bit 34, context at bits [33:30], page at bits [29:18] and frame at bits [17:0]. An entry matches only if it is valid, its page equals the address page and its context equals `ctx_i`. If nothing matches, the transfer faults.
- R5: A write through an entry whose write-allowed bit is clear faults. A read through the same entry succeeds.
- R6: When several entries match, the lowest-indexed one supplies the frame. An invalid entry with the same page does not hide a valid one at a higher index.
- R7: After a transfer is accepted, `s_hready_o` is low for exactly one cycle. It then follows `m_hready_i` until the transfer completes. A fault also completes after exactly one low cycle.
- R8: A fault issues no master transfer. It completes with `s_hready_o`=1, `s_hresp_o`=0 and `s_hrdata_o`=0, and raises `irq_o` for exactly that one cycle.
- R9: During and right after reset, `s_hready_o`=1, `m_htrans_o`=IDLE (2'b00) and `irq_o`=0.
- R10: During the memory data phase, read data from memory reaches `s_hrdata_o` and processor write data reaches `m_hwdata_o`, both unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_mode_i | input | 1 | 1 = system mode, 0 = user mode |
| ctx_i | input | 4 | Current context ID |
| tbl_i | input | 1152 | Page table, 32 entries of 36 bits |
| s_haddr_i | input | 32 | Processor address |
| s_htrans_i | input | 2 | Processor transfer type |
| s_hwrite_i | input | 1 | Processor write flag |
| s_hsize_i | input | 3 | Processor transfer size |
| s_hwdata_i | input | 32 | Processor write data |
| s_hready_o | output | 1 | Ready to processor |
| s_hresp_o | output | 1 | Response to processor |
| s_hrdata_o | output | 32 | Read data to processor |
| irq_o | output | 1 | Page-fault interrupt pulse |
| m_haddr_o | output | 32 | Memory address |
| m_htrans_o | output | 2 | Memory transfer type |
| m_hwrite_o | output | 1 | Memory write flag |
| m_hsize_o | output | 3 | Memory transfer size |
| m_hwdata_o | output | 32 | Memory write data |
| m_hready_i | input | 1 | Ready from memory |
| m_hresp_i | input | 1 | Response from memory |
| m_hrdata_i | input | 32 | Read data from memory |

## Verification
A wrong stage register or a wrong next-state choice shows up within two cycles of acceptance, in three possible ways. There may be a stray memory address phase on a fault. There may be an interrupt together with a memory access. Or the low-ready stall may be missing or too long.

A bad lookup shows up in the single master address phase, which carries the wrong frame. That wrong address is also visible in the read data the memory model returns, since that data is derived from the address. Permission or context errors show up just as fast, as a fault where a grant was due, or the other way round.

// File: rtl/vat_pkg.sv
package vat_pkg;
  parameter int ADDR_W   = 32;
  parameter int PAGE_W   = 12;
  parameter int FRAME_W  = 18;
  parameter int OFS_W    = 9;
  parameter int CTX_W    = 4;
  parameter int VIRT_BIT = 26;

  typedef struct packed {
    logic               valid;
    logic               wr_ok;
    logic [CTX_W-1:0]   ctx;
    logic [PAGE_W-1:0]  page;
    logic [FRAME_W-1:0] frame;
  } vat_entry_t;

  localparam int ENT_W = $bits(vat_entry_t);

  localparam logic [1:0] HT_IDLE   = 2'b00;
  localparam logic [1:0] HT_NONSEQ = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_DATA, ST_HOLD, ST_FDONE
  } vat_state_e;
endpackage

// File: rtl/vat_lookup.sv
module vat_lookup
  import vat_pkg::*;
#(
  parameter int N_ENT = 32
) (
  input  logic [N_ENT*ENT_W-1:0] tbl_i,
  input  logic [PAGE_W-1:0]      page_i,
  input  logic [CTX_W-1:0]       ctx_i,
  output logic                   hit_o,
  output vat_entry_t             ent_o
);
  vat_entry_t        ent [N_ENT];
  logic [N_ENT-1:0]  match;

  for (genvar k = 0; k < N_ENT; k++) begin : g_ent
    assign ent[k]   = vat_entry_t'(tbl_i[k*ENT_W +: ENT_W]);
    assign match[k] = ent[k].valid && (ent[k].page == page_i) && (ent[k].ctx == ctx_i);
  end

  // scan downward so the lowest index is assigned last
  always_comb begin
    hit_o = 1'b0;
    ent_o = '0;
    for (int k = N_ENT - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit_o = 1'b1;
        ent_o = ent[k];
      end
    end
  end
endmodule

// File: rtl/vat_decide.sv
module vat_decide
  import vat_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              sys_mode_i,
  input  logic              hit_i,
  input  vat_entry_t        ent_i,
  output logic              fault_o,
  output logic [ADDR_W-1:0] paddr_o
);
  localparam int PAD_W = ADDR_W - FRAME_W - OFS_W;

  always_comb begin
    if (!addr_i[VIRT_BIT]) begin
      paddr_o = addr_i;
      fault_o = !sys_mode_i;
    end else begin
      paddr_o = {{PAD_W{1'b0}}, ent_i.frame, addr_i[OFS_W-1:0]};
      fault_o = !hit_i || (write_i && !ent_i.wr_ok);
    end
  end
endmodule

// File: rtl/vat_check.sv
module vat_check
  import vat_pkg::*;
#(
  parameter int N_ENT = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sys_mode_i,
  input  logic [CTX_W-1:0]       ctx_i,
  input  logic [N_ENT*ENT_W-1:0] tbl_i,
  input  logic [ADDR_W-1:0]      s_haddr_i,
  input  logic [1:0]             s_htrans_i,
  input  logic                   s_hwrite_i,
  input  logic [2:0]             s_hsize_i,
  input  logic [31:0]            s_hwdata_i,
  output logic                   s_hready_o,
  output logic                   s_hresp_o,
  output logic [31:0]            s_hrdata_o,
  output logic                   irq_o,
  output logic [ADDR_W-1:0]      m_haddr_o,
  output logic [1:0]             m_htrans_o,
  output logic                   m_hwrite_o,
  output logic [2:0]             m_hsize_o,
  output logic [31:0]            m_hwdata_o,
  input  logic                   m_hready_i,
  input  logic                   m_hresp_i,
  input  logic [31:0]            m_hrdata_i
);
  vat_state_e        state_q, state_d;
  logic              hit, fault, accept;
  vat_entry_t        ent;
  logic [ADDR_W-1:0] paddr, addr_q;
  logic              write_q;
  logic [2:0]        size_q;

  vat_lookup #(.N_ENT(N_ENT)) u_lookup (
    .tbl_i  (tbl_i),
    .page_i (s_haddr_i[OFS_W +: PAGE_W]),
    .ctx_i  (ctx_i),
    .hit_o  (hit),
    .ent_o  (ent)
  );

  vat_decide u_decide (
    .addr_i     (s_haddr_i),
    .write_i    (s_hwrite_i),
    .sys_mode_i (sys_mode_i),
    .hit_i      (hit),
    .ent_i      (ent),
    .fault_o    (fault),
    .paddr_o    (paddr)
  );

  assign accept = s_hready_o && s_htrans_i[1];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = fault ? ST_HOLD : ST_ISSUE;
      ST_ISSUE: if (m_hready_i) state_d = ST_DATA;
      ST_DATA:  if (m_hready_i) state_d = accept ? (fault ? ST_HOLD : ST_ISSUE) : ST_IDLE;
      ST_HOLD:  state_d = ST_FDONE;
      ST_FDONE: state_d = accept ? (fault ? ST_HOLD : ST_ISSUE) : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      write_q <= 1'b0;
      size_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= paddr;
        write_q <= s_hwrite_i;
        size_q  <= s_hsize_i;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE, ST_FDONE: s_hready_o = 1'b1;
      ST_DATA:           s_hready_o = m_hready_i;
      default:           s_hready_o = 1'b0;
    endcase
  end

  assign s_hresp_o  = (state_q == ST_DATA) ? m_hresp_i : 1'b0;
  assign s_hrdata_o = (state_q == ST_DATA) ? m_hrdata_i : '0;
  assign irq_o      = (state_q == ST_FDONE);
  assign m_htrans_o = (state_q == ST_ISSUE) ? HT_NONSEQ : HT_IDLE;
  assign m_haddr_o  = addr_q;
  assign m_hwrite_o = write_q;
  assign m_hsize_o  = size_q;
  assign m_hwdata_o = s_hwdata_i;
endmodule

// File: rtl/vat_check_sva.sv
module vat_check_sva
  import vat_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sys_mode_i,
  input logic [ADDR_W-1:0] s_haddr_i,
  input logic [1:0]        s_htrans_i,
  input logic              s_hready_o,
  input logic              s_hresp_o,
  input logic [31:0]       s_hrdata_o,
  input logic              irq_o,
  input logic [1:0]        m_htrans_o
);
  logic acc;
  assign acc = s_hready_o && s_htrans_i[1];

  AST_ACCEPT_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !s_hready_o);  // R7
  AST_ISSUE_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_htrans_o[1] |-> !s_hready_o);  // R7
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);  // R8
  AST_FAULT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (s_hready_o && !s_hresp_o && s_hrdata_o == '0));  // R8
  AST_FAULT_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(m_htrans_o[1]));  // R8
  AST_USER_PHYS_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !sys_mode_i && !s_haddr_i[VIRT_BIT]) |=> (!m_htrans_o[1] ##1 irq_o));  // R2
endmodule

bind vat_check vat_check_sva u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sys_mode_i (sys_mode_i),
  .s_haddr_i  (s_haddr_i),
  .s_htrans_i (s_htrans_i),
  .s_hready_o (s_hready_o),
  .s_hresp_o  (s_hresp_o),
  .s_hrdata_o (s_hrdata_o),
  .irq_o      (irq_o),
  .m_htrans_o (m_htrans_o)
);

// File: tb/tb_vat_check.sv
`timescale 1ns/1ps
module tb_vat_check;
  localparam int NE = 32;
  localparam int EW = 36;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sys_mode = 1'b1;
  logic [3:0] ctx = 4'd1;
  logic [NE*EW-1:0] tbl = '0;
  logic [31:0] s_haddr = '0, s_hwdata = '0;
  logic [1:0]  s_htrans = 2'b00;
  logic        s_hwrite = 1'b0;
  logic [2:0]  s_hsize = 3'd2;
  logic        s_hready, s_hresp, irq;
  logic [31:0] s_hrdata, m_haddr, m_hwdata, m_hrdata;
  logic [1:0]  m_htrans;
  logic        m_hwrite, m_hready;
  logic [2:0]  m_hsize;

  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  vat_check dut (
    .clk_i(clk), .rst_ni(rst_n), .sys_mode_i(sys_mode), .ctx_i(ctx), .tbl_i(tbl),
    .s_haddr_i(s_haddr), .s_htrans_i(s_htrans), .s_hwrite_i(s_hwrite), .s_hsize_i(s_hsize),
    .s_hwdata_i(s_hwdata), .s_hready_o(s_hready), .s_hresp_o(s_hresp), .s_hrdata_o(s_hrdata),
    .irq_o(irq), .m_haddr_o(m_haddr), .m_htrans_o(m_htrans), .m_hwrite_o(m_hwrite),
    .m_hsize_o(m_hsize), .m_hwdata_o(m_hwdata), .m_hready_i(m_hready), .m_hresp_i(1'b0),
    .m_hrdata_i(m_hrdata)
  );

  // memory model: read data derived from the address, programmable wait states
  int wst = 0, wcnt = 0, mem_cnt = 0;
  logic        mem_pend = 1'b0, mem_wr = 1'b0;
  logic [31:0] mem_addr = '0, last_wdata = '0;
  assign m_hready = (wcnt == 0);
  assign m_hrdata = mem_addr ^ 32'h5A5A_0000;

  always @(posedge clk) begin
    if (mem_pend && m_hready) begin
      if (mem_wr) last_wdata <= m_hwdata;
      mem_pend <= 1'b0;
    end
    if (wcnt != 0) wcnt <= wcnt - 1;
    if (m_htrans[1] && m_hready) begin
      mem_pend <= 1'b1;
      mem_addr <= m_haddr;
      mem_wr   <= m_hwrite;
      mem_cnt  <= mem_cnt + 1;
      wcnt     <= wst;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic logic [35:0] mk(input bit v, input bit w, input logic [3:0] c,
                                     input logic [11:0] pg, input logic [17:0] fr);
    return {v, w, c, pg, fr};
  endfunction

  function automatic logic [31:0] va(input logic [11:0] pg, input logic [8:0] of);
    return 32'h0400_0000 | (32'(pg) << 9) | 32'(of);
  endfunction

  function automatic logic [31:0] pa(input logic [17:0] fr, input logic [8:0] of);
    return {5'b0, fr, of};
  endfunction

  logic [31:0] r_data;
  int r_irq, r_stall, r_cnt;
  logic r_resp;

  task automatic run(input logic [31:0] a, input bit wr, input logic [31:0] wd);
    int n0;
    n0 = mem_cnt;
    @(negedge clk);
    s_htrans = 2'b10; s_haddr = a; s_hwrite = wr;
    @(negedge clk);
    s_htrans = 2'b00; s_hwdata = wd;
    r_irq = 0; r_stall = 0;
    for (int g = 0; g < 50; g++) begin
      if (irq) r_irq++;
      if (s_hready) break;
      r_stall++;
      @(negedge clk);
    end
    r_data = s_hrdata; r_resp = s_hresp;
    @(negedge clk);
    if (irq) r_irq++;
    r_cnt = mem_cnt - n0;
  endtask

  task automatic expect_grant(input string tag, input logic [31:0] a, input bit wr,
                              input logic [31:0] wd, input logic [31:0] exp_pa, input int exp_stall);
    run(a, wr, wd);
    chk(r_cnt == 1, {tag, " one memory access"}, r_cnt, 1);
    chk(mem_addr == exp_pa, {tag, " memory address"}, mem_addr, exp_pa);
    chk(r_irq == 0, {tag, " no irq"}, r_irq, 0);
    chk(r_stall == exp_stall, {tag, " R7 stall cycles"}, r_stall, exp_stall);
    if (wr) chk(last_wdata == wd, {tag, " R10 write data"}, last_wdata, wd);
    else    chk(r_data == (exp_pa ^ 32'h5A5A_0000), {tag, " R10 read data"}, r_data, exp_pa ^ 32'h5A5A_0000);
  endtask

  task automatic expect_fault(input string tag, input logic [31:0] a, input bit wr);
    run(a, wr, 32'h1111_2222);
    chk(r_cnt == 0, {tag, " R8 no memory access"}, r_cnt, 0);
    chk(r_irq == 1, {tag, " R8 irq one cycle"}, r_irq, 1);
    chk(r_data == 0 && !r_resp, {tag, " R8 okay zero data"}, {r_resp, r_data}, 0);
    chk(r_stall == 1, {tag, " R7 fault stall"}, r_stall, 1);
  endtask

  task automatic t_reset;
    #1;
    chk(s_hready && m_htrans == 2'b00 && !irq, "R9 during reset", {s_hready, m_htrans, irq}, 4'b1000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(s_hready && m_htrans == 2'b00 && !irq, "R9 after reset", {s_hready, m_htrans, irq}, 4'b1000);
  endtask

  task automatic t_phys_sys;
    sys_mode = 1'b1;
    expect_grant("R1 phys sys read", 32'h0012_3456, 1'b0, '0, 32'h0012_3456, 1);
    expect_grant("R1 phys high bits", 32'h8000_0010, 1'b0, '0, 32'h8000_0010, 1);
    expect_grant("R1 phys write", 32'h0000_0200, 1'b1, 32'hCAFE_F00D, 32'h0000_0200, 1);
    chk(m_hwrite == 1'b1 && m_hsize == 3'd2, "R1 direction and size kept", {m_hwrite, m_hsize}, 4'b1010);
  endtask

  task automatic t_phys_user;
    sys_mode = 1'b0;
    expect_fault("R2 phys in user mode", 32'h0000_0100, 1'b0);
    expect_fault("R2 phys write user", 32'h0010_0000, 1'b1);
  endtask

  task automatic t_virt;
    sys_mode = 1'b0; ctx = 4'd1;
    expect_grant("R3 virt read", va(12'h012, 9'h1A5), 1'b0, '0, pa(18'h00ABC, 9'h1A5), 1);
    expect_grant("R3 upper bits ignored", va(12'h012, 9'h004) | 32'hF9E0_0000, 1'b0, '0,
                 pa(18'h00ABC, 9'h004), 1);
    expect_grant("R5 virt write allowed", va(12'h012, 9'h003), 1'b1, 32'hDEAD_BEEF,
                 pa(18'h00ABC, 9'h003), 1);
  endtask

  task automatic t_perm;
    ctx = 4'd1;
    expect_grant("R5 read-only read", va(12'h034, 9'h010), 1'b0, '0, pa(18'h01234, 9'h010), 1);
    expect_fault("R5 read-only write", va(12'h034, 9'h010), 1'b1);
  endtask

  task automatic t_miss;
    ctx = 4'd1;
    expect_fault("R4 invalid entry", va(12'h056, 9'h000), 1'b0);
    expect_fault("R4 unmapped page", va(12'h100, 9'h0FF), 1'b0);
    expect_fault("R4 context mismatch", va(12'h078, 9'h001), 1'b0);
    ctx = 4'd2;
    expect_grant("R4 context match", va(12'h078, 9'h1FF), 1'b0, '0, pa(18'h3FFFF, 9'h1FF), 1);
    ctx = 4'd1;
  endtask

  task automatic t_dup;
    ctx = 4'd1;
    expect_grant("R6 lowest index wins", va(12'h0AA, 9'h020), 1'b0, '0, pa(18'h00111, 9'h020), 1);
    expect_grant("R6 invalid lower skipped", va(12'h0BB, 9'h021), 1'b0, '0, pa(18'h00777, 9'h021), 1);
  endtask

  task automatic t_wait;
    sys_mode = 1'b1; wst = 2;
    expect_grant("R7 wait states", 32'h0000_0400, 1'b0, '0, 32'h0000_0400, 3);
    expect_grant("R7 virt wait", va(12'h012, 9'h0), 1'b0, '0, pa(18'h00ABC, 9'h0), 3);
    wst = 0;
  endtask

  initial begin
    tbl[0*EW +: EW] = mk(1, 1, 4'd1, 12'h012, 18'h00ABC);
    tbl[1*EW +: EW] = mk(1, 0, 4'd1, 12'h034, 18'h01234);
    tbl[2*EW +: EW] = mk(0, 1, 4'd1, 12'h056, 18'h00002);
    tbl[3*EW +: EW] = mk(1, 1, 4'd2, 12'h078, 18'h3FFFF);
    tbl[4*EW +: EW] = mk(0, 1, 4'd1, 12'h0BB, 18'h00005);
    tbl[5*EW +: EW] = mk(1, 1, 4'd1, 12'h0AA, 18'h00111);
    tbl[7*EW +: EW] = mk(1, 1, 4'd1, 12'h0BB, 18'h00777);
    tbl[9*EW +: EW] = mk(1, 1, 4'd1, 12'h0AA, 18'h00222);
    t_reset();
    t_phys_sys();
    t_phys_user();
    t_virt();
    t_perm();
    t_miss();
    t_dup();
    t_wait();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule